// File: doc/BRIEF.md
# MFM Clock/Data Pair Decoder

This block turns a stream of raw channel bits from a disk read channel into decoded data. Each raw bit arrives with a valid strobe and says whether a flux reversal was seen in that cell. Consecutive raw bits are grouped in twos: the first bit of a group is the clock position and the second is the data position. Every group decodes to one data bit. Whether a group is legal depends on the data bit decoded just before it, so the block keeps one bit of history.

Decoded bits come out one at a time with a valid strobe, and are also gathered into bytes for a parallel host port. An align input restarts the grouping on the next raw bit. Upstream logic uses it after it finds a sync pattern. Groups that cannot occur in a correctly encoded stream raise an error pulse.

Top module: `mfmdec_top`

## Requirements
- R1: Two accepted raw bits make one data bit. `data_valid_o` is high for exactly the one cycle after the clock edge that accepts the second raw bit of a pair. It is never high after the first bit of a pair alone.
- R2: A pair of no reversal followed by reversal decodes to 1, whatever the history.
- R3: A pair of reversal followed by no reversal decodes to 0 without error when the previous data bit is 0.
- R4: A pair of no reversal followed by no reversal decodes to 0 without error when the previous data bit is 1.
- R5: A pair of reversal followed by reversal decodes to 0. It pulses `pair_err_o` in the same cycle as `data_valid_o`.
- R6: The pair reversal followed by no reversal after a previous 1 is an error. So is the pair no reversal followed by no reversal after a previous 0. Each decodes to 0 with a one-cycle `pair_err_o` pulse. In every case the decoded value, including an error's 0, becomes the new history.
- R7: A cycle with `align_i` high produces no data. The next accepted raw bit, including one in that same cycle, is the first bit of a pair. The history becomes 0, and a partially assembled byte is discarded.
- R8: Data bits are packed most significant bit first. `byte_valid_o` and the full byte on `byte_o` appear in the same cycle as the `data_valid_o` of the eighth bit since reset or alignment. The newest bit sits in bit 0.
- R9: The parameter `REV_LEVEL` (default 1) sets which value of `raw_bit_i` means a reversal. With the default, 1 is a reversal and 0 is none.
- R10: After reset all outputs are 0 and the history is 0.
- R11: `raw_bit_i` is ignored while `raw_valid_i` is low. Such cycles produce no output and do not move the pair phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| align_i | input | 1 | Restart pair grouping and clear history |
| raw_bit_i | input | 1 | Raw channel bit (reversal or none) |
| raw_valid_i | input | 1 | Raw bit strobe |
| data_bit_o | output | 1 | Decoded data bit |
| data_valid_o | output | 1 | Decoded bit strobe |
| byte_o | output | BYTE_W | Assembled byte, first bit in the MSB |
| byte_valid_o | output | 1 | Byte strobe |
| pair_err_o | output | 1 | Illegal pair pulse |

## Verification
The assertions rely on the raw strobe delivering at most one raw bit per cycle. Under that assumption a pair can complete at most every second cycle, and an alignment cycle can never complete one. The bench drives raw bits at the falling edge, one per cycle at most, and keeps `align_i` apart from the second bit of a pair. The only exception is a deliberate case where align and a raw bit arrive together, to show that bit starts a new pair. The bench builds legal streams with its own encoder and inserts illegal pairs explicitly.

// File: rtl/mfmdec_pkg.sv
package mfmdec_pkg;
    typedef struct packed {
        logic half;
        logic first_rev;
    } collect_t;

    typedef struct packed {
        logic prev;
        logic bit_v;
        logic valid;
        logic err;
    } decode_t;
endpackage

// File: rtl/mfmdec_collect.sv
module mfmdec_collect
    import mfmdec_pkg::*;
#(
    parameter bit REV_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic align_i,
    input  logic raw_bit_i,
    input  logic raw_valid_i,
    output logic pair_valid_o,
    output logic first_rev_o,
    output logic second_rev_o
);
    collect_t st_d, st_q;
    logic     rev_now;

    assign rev_now = (raw_bit_i == REV_LEVEL);

    always_comb begin
        st_d = st_q;
        if (align_i) begin
            st_d.half = 1'b0;
        end
        if (raw_valid_i) begin
            if (align_i || !st_q.half) begin
                st_d.half      = 1'b1;
                st_d.first_rev = rev_now;
            end else begin
                st_d.half = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pair_valid_o = raw_valid_i && st_q.half && !align_i;
    assign first_rev_o  = st_q.first_rev;
    assign second_rev_o = rev_now;
endmodule

// File: rtl/mfmdec_decode.sv
module mfmdec_decode
    import mfmdec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic align_i,
    input  logic pair_valid_i,
    input  logic first_rev_i,
    input  logic second_rev_i,
    output logic dec_valid_o,
    output logic dec_bit_o,
    output logic data_bit_o,
    output logic data_valid_o,
    output logic err_o
);
    decode_t st_d, st_q;
    logic    bit_c, err_c;

    always_comb begin
        unique case ({first_rev_i, second_rev_i})
            2'b01:   begin bit_c = 1'b1; err_c = 1'b0;       end
            2'b10:   begin bit_c = 1'b0; err_c = st_q.prev;  end
            2'b00:   begin bit_c = 1'b0; err_c = !st_q.prev; end
            default: begin bit_c = 1'b0; err_c = 1'b1;       end
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = pair_valid_i;
        st_d.err   = pair_valid_i && err_c;
        if (pair_valid_i) st_d.bit_v = bit_c;
        if (align_i)           st_d.prev = 1'b0;
        else if (pair_valid_i) st_d.prev = bit_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dec_valid_o  = pair_valid_i;
    assign dec_bit_o    = bit_c;
    assign data_bit_o   = st_q.bit_v;
    assign data_valid_o = st_q.valid;
    assign err_o        = st_q.err;
endmodule

// File: rtl/mfmdec_pack.sv
module mfmdec_pack #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              align_i,
    input  logic              bit_valid_i,
    input  logic              bit_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_valid_o
);
    localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shift;
        logic [BYTE_W-1:0] out;
        logic              vld;
    } pack_t;

    pack_t            st_d, st_q;
    logic [BYTE_W-1:0] shifted;

    assign shifted = {st_q.shift[BYTE_W-2:0], bit_i};

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (align_i) begin
            st_d.cnt   = '0;
            st_d.shift = '0;
        end else if (bit_valid_i) begin
            st_d.shift = shifted;
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                st_d.out = shifted;
                st_d.vld = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte_o       = st_q.out;
    assign byte_valid_o = st_q.vld;
endmodule

// File: rtl/mfmdec_top.sv
module mfmdec_top #(
    parameter int BYTE_W    = 8,
    parameter bit REV_LEVEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              align_i,
    input  logic              raw_bit_i,
    input  logic              raw_valid_i,
    output logic              data_bit_o,
    output logic              data_valid_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_valid_o,
    output logic              pair_err_o
);
    logic pair_valid, first_rev, second_rev;
    logic dec_valid, dec_bit;

    mfmdec_collect #(.REV_LEVEL(REV_LEVEL)) u_collect (
        .clk(clk), .rst_n(rst_n), .align_i(align_i),
        .raw_bit_i(raw_bit_i), .raw_valid_i(raw_valid_i),
        .pair_valid_o(pair_valid), .first_rev_o(first_rev),
        .second_rev_o(second_rev)
    );

    mfmdec_decode u_decode (
        .clk(clk), .rst_n(rst_n), .align_i(align_i),
        .pair_valid_i(pair_valid), .first_rev_i(first_rev),
        .second_rev_i(second_rev), .dec_valid_o(dec_valid),
        .dec_bit_o(dec_bit), .data_bit_o(data_bit_o),
        .data_valid_o(data_valid_o), .err_o(pair_err_o)
    );

    mfmdec_pack #(.BYTE_W(BYTE_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .align_i(align_i),
        .bit_valid_i(dec_valid), .bit_i(dec_bit),
        .byte_o(byte_o), .byte_valid_o(byte_valid_o)
    );
endmodule

// File: rtl/mfmdec_checker.sv
module mfmdec_checker #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              align_i,
    input logic              data_bit_o,
    input logic              data_valid_o,
    input logic [BYTE_W-1:0] byte_o,
    input logic              byte_valid_o,
    input logic              pair_err_o
);
    AST_PAIR_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid_o |=> !data_valid_o);                          // R1
    AST_ERR_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pair_err_o |-> data_valid_o);                             // R5
    AST_ERR_DECODES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pair_err_o |-> !data_bit_o);                              // R6
    AST_ALIGN_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        align_i |=> !data_valid_o);                               // R7
    AST_BYTE_WITH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> data_valid_o);                           // R8
    AST_BYTE_NEWEST_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> (byte_o[0] == data_bit_o));              // R8
endmodule

bind mfmdec_top mfmdec_checker #(.BYTE_W(BYTE_W)) u_mfmdec_checker (
    .clk(clk), .rst_n(rst_n), .align_i(align_i),
    .data_bit_o(data_bit_o), .data_valid_o(data_valid_o),
    .byte_o(byte_o), .byte_valid_o(byte_valid_o), .pair_err_o(pair_err_o)
);

// File: tb/mfmdec_top_bench.sv
module mfmdec_top_bench;
    localparam int BW = 8;
    logic clk = 1'b0, rst_n = 1'b0;
    logic align_i = 1'b0, raw_bit_i = 1'b0, raw_valid_i = 1'b0;
    logic data_bit_o, data_valid_o, byte_valid_o, pair_err_o;
    logic [BW-1:0] byte_o;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic hist = 1'b0;

    always #10 clk = ~clk;

    mfmdec_top u_mfmdec_top (
        .clk(clk), .rst_n(rst_n), .align_i(align_i), .raw_bit_i(raw_bit_i),
        .raw_valid_i(raw_valid_i), .data_bit_o(data_bit_o),
        .data_valid_o(data_valid_o), .byte_o(byte_o),
        .byte_valid_o(byte_valid_o), .pair_err_o(pair_err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // one raw bit; returns at the falling edge after it was accepted
    task automatic push(input logic b);
        raw_valid_i = 1'b1; raw_bit_i = b;
        @(negedge clk);
        raw_valid_i = 1'b0; raw_bit_i = ~b;
    endtask

    // R9: with the default polarity, 1 is a reversal
    task automatic pair(input logic c, input logic d, input logic exp_bit,
                        input logic exp_err, input string req);
        push(c);
        chk(data_valid_o == 1'b0, "R1", data_valid_o, 0);
        push(d);
        chk(data_valid_o == 1'b1, "R1", data_valid_o, 1);
        chk(data_bit_o == exp_bit, req, data_bit_o, exp_bit);
        chk(pair_err_o == exp_err, req, pair_err_o, exp_err);
        hist = exp_bit;
    endtask

    task automatic do_align();
        align_i = 1'b1;
        @(negedge clk);
        align_i = 1'b0;
        chk(data_valid_o == 1'b0, "R7", data_valid_o, 0);
        hist = 1'b0;
    endtask

    // legal encoding of one data bit from the bench's own history
    task automatic send_bit(input logic b, input string req);
        logic c;
        c = (!hist && !b);
        pair(c, b, b, 1'b0, req);
    endtask

    task automatic send_byte(input logic [BW-1:0] v, input string req);
        for (int i = BW - 1; i >= 0; i--) begin
            send_bit(v[i], req);
            if (i != 0) chk(byte_valid_o == 1'b0, "R8", byte_valid_o, 0);
        end
        chk(byte_valid_o == 1'b1, "R8", byte_valid_o, 1);
        chk(byte_o == v, req, byte_o, v);
    endtask

    task automatic t_reset();
        chk({data_valid_o, data_bit_o, byte_valid_o, pair_err_o} == 4'b0, "R10",
            {data_valid_o, data_bit_o, byte_valid_o, pair_err_o}, 0);
        chk(byte_o == '0, "R10", byte_o, 0);
        pair(1'b1, 1'b0, 1'b0, 1'b0, "R10"); // history 0 after reset: RN is legal
    endtask

    task automatic t_rules();
        do_align();
        pair(1'b0, 1'b1, 1'b1, 1'b0, "R2");
        pair(1'b0, 1'b0, 1'b0, 1'b0, "R4");
        pair(1'b1, 1'b0, 1'b0, 1'b0, "R3");
        pair(1'b0, 1'b1, 1'b1, 1'b0, "R2");
        pair(1'b0, 1'b1, 1'b1, 1'b0, "R2");
        pair(1'b1, 1'b0, 1'b0, 1'b1, "R6");
        pair(1'b0, 1'b0, 1'b0, 1'b1, "R6");
        pair(1'b1, 1'b1, 1'b0, 1'b1, "R5");
        pair(1'b1, 1'b0, 1'b0, 1'b0, "R6"); // history was 0 after the error
        @(negedge clk);
        chk(pair_err_o == 1'b0, "R5", pair_err_o, 0);
    endtask

    task automatic t_bytes();
        do_align();
        send_byte(8'hA5, "R8");
        send_byte(8'h00, "R8");
        send_byte(8'hFF, "R8");
    endtask

    task automatic t_align();
        do_align();
        pair(1'b0, 1'b1, 1'b1, 1'b0, "R7");
        do_align();
        pair(1'b1, 1'b0, 1'b0, 1'b0, "R7"); // history cleared
        push(1'b0);                          // stray half pair
        do_align();
        pair(1'b0, 1'b1, 1'b1, 1'b0, "R7");
        // align together with a raw bit: that bit opens the new pair
        push(1'b1);
        align_i = 1'b1; raw_valid_i = 1'b1; raw_bit_i = 1'b0;
        @(negedge clk);
        align_i = 1'b0; raw_valid_i = 1'b0;
        chk(data_valid_o == 1'b0, "R7", data_valid_o, 0);
        push(1'b1);
        chk(data_valid_o && data_bit_o && !pair_err_o, "R7",
            {data_valid_o, data_bit_o, pair_err_o}, 3'b110);
        hist = 1'b1;
        // partial byte discarded
        send_bit(1'b1, "R7"); send_bit(1'b0, "R7"); send_bit(1'b1, "R7");
        do_align();
        send_byte(8'h3C, "R7");
    endtask

    task automatic t_ignore();
        do_align();
        push(1'b0);
        for (int i = 0; i < 6; i++) begin
            raw_bit_i = i[0];
            @(negedge clk);
            chk(data_valid_o == 1'b0, "R11", data_valid_o, 0);
        end
        push(1'b1);
        chk(data_valid_o && data_bit_o && !pair_err_o, "R11",
            {data_valid_o, data_bit_o, pair_err_o}, 3'b110);
        hist = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rules();
        t_bytes();
        t_align();
        t_ignore();
        repeat (2) @(negedge clk);
        finish_up();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_up();
    end
endmodule